// File: doc/BRIEF.md
# Serial ADC Conversion Cycle Controller

This block is the digital side of a single-channel converter that hands its results to a host over a three-wire, read-only serial port. It runs a fixed loop. First it runs a timed conversion. Then it sleeps with the finished result held. When the host asks for the result, it shifts the result out. Every read, whether complete or cut short, starts the next conversion. The analog modulator and its filter are outside the block. A behavioural core supplies each 16-bit result together with a valid strobe.

The host controls the port with an active-low select and a serial clock. Both are brought into the system-clock domain through two-flop synchronizers. The block leaves sleep only when both of them are low. It then presents the sign bit and moves one bit towards the LSB on each following falling clock edge, so the host samples on rising edges.

While select is low and a conversion runs, the data line is held high as a busy flag. It drops low once the result is ready. A power-good input acts as the power-on reset. Once power-good rises, a timed settling interval passes before the first conversion starts.

Top module: `adc_cycle_ctrl`

## Requirements
- R1: The states follow one fixed order: reset settle, then convert, then sleep, then data output, then convert again. `conv_start` pulses once on each entry into convert.
- R2: A conversion lasts exactly `CONV_CYCLES` system clocks. Select and serial clock activity neither shortens it nor aborts it. `conv_start` is high for exactly the first cycle of the conversion.
- R3: Sleep is left for data output only when the synchronized select and serial clock are both low. With select low and the clock high, the block stays asleep and drives `sdo` low.
- R4: `low_power` is 1 exactly while the block is asleep and the synchronized select is high. It is 0 in every other case.
- R5: The result register loads `core_result` only when `core_valid` is high during a conversion. A strobe during sleep or data output leaves the value that is read out unchanged.
- R6: On entering data output, `sdo` shows bit 15 of the held result. Each later synchronized falling clock edge shows the next lower bit, down to bit 0.
- R7: Data output ends on the 16th synchronized falling clock edge, or earlier on a synchronized rising edge of select. Either way a conversion starts on the next clock.
- R8: `sdo_oe` equals the inverse of select, delayed by the two synchronizer flops: the line is driven while select is low and released while it is high.
- R9: With the line enabled, `sdo` is 1 during settling and conversion, and 0 during sleep.
- R10: While `pwr_ok` is low, all state is cleared: `sdo_oe`, `low_power` and `conv_start` are 0 and the result is zero. `POR_CYCLES` clocks after `pwr_ok` rises, a conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_ok | input | 1 | Power good; low acts as the asynchronous power-on reset |
| cs_n | input | 1 | Serial select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from the host, asynchronous to clk |
| core_valid | input | 1 | Strobe from the conversion core: `core_result` is valid |
| core_result | input | 16 | Two's-complement result from the conversion core |
| sdo | output | 1 | Serial data or busy flag |
| sdo_oe | output | 1 | Output enable for the tri-state `sdo` pad |
| low_power | output | 1 | Low-power indication while asleep and deselected |
| conv_start | output | 1 | One-cycle pulse at the start of each conversion |

## Verification
The bench checks the sleep exit with select low and the clock still high. A block that wrongly required only select would start shifting there, and `sdo` would show the sign bit instead of 0. A read is aborted after five bits to check the early ending. A block without it would stay in data output and never pulse `conv_start` again. The bench also pulses the core strobe during sleep. A block that latched it there would read back the wrong word. A power dip in the middle of a conversion checks that the cycle restarts after the settle interval. The 16th falling edge is checked in the same way: a block that counted one edge too many or too few would be caught, because its busy flag would rise one bit late or one bit early.

// File: rtl/adc_cycle_ctrl.sv
module adc_cycle_ctrl #(
  parameter int CONV_CYCLES = 2075000,
  parameter int POR_CYCLES  = 62500,
  parameter int RES_W       = 16
) (
  input  logic             clk,
  input  logic             pwr_ok,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             core_valid,
  input  logic [RES_W-1:0] core_result,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             low_power,
  output logic             conv_start
);
  localparam int TIM_W = $clog2(CONV_CYCLES);
  localparam int POR_W = $clog2(POR_CYCLES);
  localparam int IDX_W = $clog2(RES_W);

  typedef enum logic [1:0] {ST_POR, ST_CONV, ST_SLEEP, ST_DATA} st_t;

  st_t              st;
  logic [TIM_W-1:0] tim;
  logic [POR_W-1:0] por_cnt;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] res_q;
  logic             cs_m, cs_s, cs_d, sck_m, sck_s, sck_d;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      {cs_m, cs_s, cs_d}    <= 3'b111;
      {sck_m, sck_s, sck_d} <= 3'b111;
    end else begin
      {cs_m, cs_s, cs_d}    <= {cs_n, cs_m, cs_s};
      {sck_m, sck_s, sck_d} <= {sclk, sck_m, sck_s};
    end
  end

  wire sck_fall = sck_d & ~sck_s;
  wire cs_rise  = cs_s & ~cs_d;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      st         <= ST_POR;
      tim        <= '0;
      por_cnt    <= '0;
      idx        <= '0;
      res_q      <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      case (st)
        ST_POR: begin
          if (por_cnt == POR_W'(POR_CYCLES - 1)) begin
            st         <= ST_CONV;
            tim        <= '0;
            conv_start <= 1'b1;
          end else begin
            por_cnt <= por_cnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (core_valid) res_q <= core_result;
          if (tim == TIM_W'(CONV_CYCLES - 1)) st <= ST_SLEEP;
          else tim <= tim + 1'b1;
        end
        ST_SLEEP: begin
          if (!cs_s && !sck_s) begin
            st  <= ST_DATA;
            idx <= IDX_W'(RES_W - 1);
          end
        end
        default: begin
          if (cs_rise || (sck_fall && idx == '0)) begin
            st         <= ST_CONV;
            tim        <= '0;
            conv_start <= 1'b1;
          end else if (sck_fall) begin
            idx <= idx - 1'b1;
          end
        end
      endcase
    end
  end

  assign sdo_oe    = ~cs_s;
  assign sdo       = (st == ST_DATA) ? res_q[idx] : (st != ST_SLEEP);
  assign low_power = (st == ST_SLEEP) && cs_s;

  a_r1_sleep_exit: assert property (@(posedge clk) disable iff (!pwr_ok)
    (st == ST_SLEEP) |=> (st == ST_SLEEP || st == ST_DATA));

  a_r2_conv_holds: assert property (@(posedge clk) disable iff (!pwr_ok)
    (st == ST_CONV && tim != TIM_W'(CONV_CYCLES - 1)) |=> (st == ST_CONV && !conv_start));

  a_r3_need_both_low: assert property (@(posedge clk) disable iff (!pwr_ok)
    (st == ST_SLEEP && (cs_s || sck_s)) |=> (st == ST_SLEEP));

  a_r5_result_held: assert property (@(posedge clk) disable iff (!pwr_ok)
    (st == ST_SLEEP) |=> $stable(res_q));

  a_r6_sign_first: assert property (@(posedge clk) disable iff (!pwr_ok)
    (st == ST_SLEEP && !cs_s && !sck_s) |=> (sdo == res_q[RES_W-1]));

  a_r7_restart: assert property (@(posedge clk) disable iff (!pwr_ok)
    (st == ST_DATA) |=> (st == ST_DATA || (st == ST_CONV && conv_start)));
endmodule

// File: tb/tb_adc_cycle_ctrl.sv
module tb_adc_cycle_ctrl;
  localparam int CONV = 40;
  localparam int PORC = 8;

  logic clk = 1'b0;
  logic pwr_ok = 1'b0, cs_n = 1'b1, sclk = 1'b1, core_valid = 1'b0;
  logic [15:0] core_result = '0;
  logic sdo, sdo_oe, low_power, conv_start;

  always #4 clk = ~clk;

  adc_cycle_ctrl #(.CONV_CYCLES(CONV), .POR_CYCLES(PORC), .RES_W(16)) dut (
    .clk(clk), .pwr_ok(pwr_ok), .cs_n(cs_n), .sclk(sclk),
    .core_valid(core_valid), .core_result(core_result),
    .sdo(sdo), .sdo_oe(sdo_oe), .low_power(low_power), .conv_start(conv_start));

  int nchk = 0, nerr = 0, nstarts = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 settle, 1 convert, 2 sleep, 3 data
  int mst = 0, mpor = 0, mtim = 0, midx = 0;
  int c1 = 1, cs = 1, cd = 1, k1 = 1, ks = 1, kd = 1;
  logic [15:0] mres = '0;
  bit mstart = 0;

  always @(posedge clk) begin
    if (!pwr_ok) begin
      mst = 0; mpor = 0; mtim = 0; midx = 0; mres = '0; mstart = 0;
      c1 = 1; cs = 1; cd = 1; k1 = 1; ks = 1; kd = 1;
    end else begin
      mstart = 0;
      case (mst)
        0: if (mpor == PORC - 1) begin mst = 1; mtim = 0; mstart = 1; end
           else mpor++;
        1: begin
          if (core_valid) mres = core_result;
          if (mtim == CONV - 1) mst = 2; else mtim++;
        end
        2: if (cs == 0 && ks == 0) begin mst = 3; midx = 15; end
        default: begin
          if ((cs == 1 && cd == 0) || (kd == 1 && ks == 0 && midx == 0)) begin
            mst = 1; mtim = 0; mstart = 1;
          end else if (kd == 1 && ks == 0) midx--;
        end
      endcase
      cd = cs; cs = c1; c1 = int'(cs_n);
      kd = ks; ks = k1; k1 = int'(sclk);
    end
  end

  always @(negedge clk) begin
    if (!pwr_ok) begin
      chk(!sdo_oe && !low_power && !conv_start, "R10", "outputs in reset",
          {sdo_oe, low_power, conv_start}, 0);
    end else begin
      chk(sdo_oe == (cs == 0), "R8", "sdo_oe", sdo_oe, cs == 0);
      chk(low_power == (mst == 2 && cs == 1), "R4", "low_power", low_power, mst == 2 && cs == 1);
      chk(conv_start == mstart, "R2", "conv_start", conv_start, mstart);
      if (sdo_oe) begin
        if (mst == 3) chk(sdo == mres[midx], "R6", "sdo data bit", sdo, mres[midx]);
        else chk(sdo == (mst != 2), "R9", "sdo busy flag", sdo, mst != 2);
      end
      if (conv_start) nstarts++;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_st(int s);
    while (mst != s) step(1);
  endtask

  task automatic pulse_core(logic [15:0] v);
    core_result = v; core_valid = 1'b1;
    step(1);
    core_valid = 1'b0;
  endtask

  task automatic read_bits(int n, output logic [15:0] w);
    w = '0;
    sclk = 1'b0;
    step(6);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; step(4);
      w = {w[14:0], sdo};
      sclk = 1'b0; step(6);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    step(5);
    chk(!sdo_oe && !low_power && !conv_start, "R10", "reset state", 0, 0);
    pwr_ok = 1'b1;
    wait_st(1);
    step(3);
    pulse_core(16'hA5C3);
    cs_n = 1'b0; step(4);
    chk(sdo == 1'b1 && sdo_oe, "R9", "busy while converting", sdo, 1);
    sclk = 1'b0; step(3); sclk = 1'b1; step(2); cs_n = 1'b1; step(3); cs_n = 1'b0;
    sclk = 1'b0; step(4);
    chk(mst == 1, "R2", "conversion not aborted", mst, 1);
    cs_n = 1'b1; sclk = 1'b1;
    wait_st(2);
    step(4);
    chk(low_power == 1'b1, "R4", "low power when deselected", low_power, 1);
    pulse_core(16'h1234);
    cs_n = 1'b0; step(10);
    chk(sdo == 1'b0 && sdo_oe && !low_power, "R3", "stays asleep with clock high", sdo, 0);
    read_bits(16, w);
    chk(w == 16'hA5C3, "R5", "word read after strobe in sleep", w, 16'hA5C3);
    chk(mst == 1, "R7", "16th fall restarts conversion", mst, 1);
    sclk = 1'b1;
    pulse_core(16'h8001);
    wait_st(2);
    read_bits(5, w);
    chk(w == 16'h0010, "R6", "first five bits msb first", w, 16'h0010);
    cs_n = 1'b1; step(5);
    chk(nstarts == 3, "R7", "select rise aborts read", nstarts, 3);
    pulse_core(16'h7FFE);
    cs_n = 1'b0;
    wait_st(2);
    step(2);
    read_bits(16, w);
    chk(w == 16'h7FFE, "R6", "positive full word", w, 16'h7FFE);
    step(5);
    pwr_ok = 1'b0; step(3);
    chk(mst == 0 && !sdo_oe, "R10", "power dip clears state", sdo_oe, 0);
    pwr_ok = 1'b1; sclk = 1'b1;
    step(PORC - 1);
    chk(nstarts == 4, "R10", "no start before settle", nstarts, 4);
    wait_st(1);
    pulse_core(16'h0F0F);
    wait_st(2);
    read_bits(16, w);
    chk(w == 16'h0F0F, "R10", "read after power dip", w, 16'h0F0F);
    step(3);
    chk(nstarts == 6, "R1", "conversion starts counted", nstarts, 6);
    finish_run();
  end
endmodule